// File: doc/BRIEF.md
# Receive BIST Pattern Checker

This block sits behind the character decoder of a serial receive channel and verifies a built-in self-test stream. Characters arrive already framed and decoded: one 8-bit value per valid strobe, plus a flag that marks control (special) characters. The checker keeps an 8-bit pseudo-random reference generator. While hunting, it waits for the data character 0x00, which starts each test pass. Once it has locked, it compares every following valid character with the reference and advances the reference by one step per valid character.

Progress is reported on a registered 3-bit status code together with one-cycle pass, error and abort pulses. A saturating balance counts mismatches against matches. When mismatches lead by sixteen, the checker gives up, clears its generator back to zero and starts hunting again. Control characters received while hunting, such as a word-sync preamble ahead of each pass, are skipped without effect. Because misframed input has no special handling, it simply shows up as mismatches.

Top module: `rx_bist_checker`

## Requirements
- R1: During reset, status is 000 and pass, err and abort are low. On the clock after `bist_en` is sampled low, the same idle outputs appear, and any run in progress is dropped.
- R2: While hunting, every valid character other than data 0x00 with `chr_ctl`=0 gives status 000 and leaves the checker hunting. This includes control characters of a word-sync preamble and nonzero data.
- R3: While hunting, a valid data character 0x00 (`chr_ctl`=0) locks the checker. Status becomes 001, and the reference advances once from 0x00.
- R4: The reference advances as an 8-bit left shift whose new bit 0 is NOT(b7 XOR b5 XOR b4 XOR b3) of the old value, giving a 255-state sequence starting from 0x00. A valid data character equal to the reference gives status 001.
- R5: While locked, a valid character that differs from the reference, or that has `chr_ctl`=1, gives status 010 and a one-cycle err pulse. The reference still advances.
- R6: Status changes only on clocks that sample `chr_vld`=1 (or on disable or reset). pass, err and abort are high for one clock only.
- R7: The balance rises by one on each mismatch and falls by one on each match, but never below zero. Matches cannot bank credit, so a run of good characters followed by 16 mismatches aborts on the 16th.
- R8: An abort gives status 100 and an abort pulse, returns to hunting, and resets the reference to 0x00. The next 0x00 relocks the checker and the sequence restarts.
- R9: The 255th character of a pass (the one whose next reference value would be 0x00) ends the pass. On a match it gives status 011 and a pass pulse. The checker then hunts again with a cleared balance.
- R10: If the final character of a pass mismatches, the checker gives status 010 and err instead of 011 and pass, and still returns to hunting. If that mismatch is also the 16th excess mismatch, the abort of R8 takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_en | input | 1 | Receive self-test enable |
| chr_vld | input | 1 | Character valid strobe |
| chr_data | input | 8 | Decoded character value |
| chr_ctl | input | 1 | High for a control/special character |
| status | output | 3 | Registered status code |
| pass | output | 1 | One-cycle pulse when a pass completes correctly |
| err | output | 1 | One-cycle pulse on a mismatch |
| abort | output | 1 | One-cycle pulse when the balance limit is hit |

## Verification
Every result is registered once. Status and the three pulses reflect the inputs sampled at a clock edge and become visible right after that same edge, so the response to each character is due exactly one cycle after it is presented. This also holds for the return to idle after `bist_en` drops. The bench drives inputs on the falling edge and advances a behavioural model at the rising edge. It then compares status, pass, err and abort with the model shortly after that edge on every clock, including idle cycles, which checks the hold and single-cycle pulse behaviour.

// File: rtl/rx_bist_pkg.sv
package rx_bist_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'b000,
        ST_MATCH = 3'b001,
        ST_MISM  = 3'b010,
        ST_END   = 3'b011,
        ST_ABORT = 3'b100
    } bist_status_e;

    typedef enum logic {
        PH_HUNT = 1'b0,
        PH_RUN  = 1'b1
    } bist_phase_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              ctl;
    } rx_char_t;

    typedef struct packed {
        bist_status_e code;
        logic         pass;
        logic         err;
        logic         abort;
    } bist_report_t;

endpackage

// File: rtl/rx_bist_refgen.sv
module rx_bist_refgen #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] ref_o,
    output logic         last_o
);
    function automatic logic [W-1:0] advance(input logic [W-1:0] s);
        logic fb;
        fb = ~(^(s & TAPS));
        return {s[W-2:0], fb};
    endfunction

    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            state_q <= '0;
        else if (step)
            state_q <= advance(state_q);
    end

    assign ref_o  = state_q;
    assign last_o = (advance(state_q) == '0);

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
        state_q != '1);  // R4

endmodule

// File: rtl/rx_bist_balance.sv
module rx_bist_balance #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic good,
    input  logic bad,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign hit_o = bad && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst || clr || hit_o)
            cnt_q <= '0;
        else if (bad)
            cnt_q <= cnt_q + 1'b1;
        else if (good && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    AST_BAL_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(LIMIT));  // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (good && !bad && !clr && cnt_q == '0) |=> cnt_q == '0);  // R7

endmodule

// File: rtl/rx_bist_checker.sv
module rx_bist_checker
    import rx_bist_pkg::*;
#(
    parameter int          W     = CHAR_W,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter int          LIMIT = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bist_en,
    input  logic         chr_vld,
    input  logic [W-1:0] chr_data,
    input  logic         chr_ctl,
    output logic [2:0]   status,
    output logic         pass,
    output logic         err,
    output logic         abort
);
    bist_phase_e  phase_q;
    bist_report_t rep_q;
    logic [W-1:0] ref_w;
    logic         last_w, hit_w;
    logic         is_start, is_match, run_chr, hunt_chr;
    logic         restart, gen_clr, gen_step, bal_clr;

    assign hunt_chr = chr_vld && (phase_q == PH_HUNT);
    assign run_chr  = chr_vld && (phase_q == PH_RUN);
    assign is_start = !chr_ctl && (chr_data == '0);
    assign is_match = !chr_ctl && (chr_data == ref_w);

    assign restart  = run_chr && (hit_w || last_w);
    assign gen_clr  = !bist_en || restart;
    assign gen_step = (hunt_chr && is_start) || run_chr;
    assign bal_clr  = !bist_en || (run_chr && last_w);

    rx_bist_refgen #(.W(W), .TAPS(TAPS)) u_refgen (
        .clk   (clk),
        .rst   (rst),
        .clr   (gen_clr),
        .step  (gen_step),
        .ref_o (ref_w),
        .last_o(last_w)
    );

    rx_bist_balance #(.LIMIT(LIMIT)) u_balance (
        .clk  (clk),
        .rst  (rst),
        .clr  (bal_clr),
        .good (run_chr && is_match),
        .bad  (run_chr && !is_match),
        .hit_o(hit_w)
    );

    always_ff @(posedge clk) begin
        if (rst || !bist_en) begin
            phase_q <= PH_HUNT;
            rep_q   <= '{code: ST_IDLE, pass: 1'b0, err: 1'b0, abort: 1'b0};
        end else begin
            rep_q.pass  <= 1'b0;
            rep_q.err   <= 1'b0;
            rep_q.abort <= 1'b0;
            if (hunt_chr) begin
                if (is_start) begin
                    phase_q    <= PH_RUN;
                    rep_q.code <= ST_MATCH;
                end else begin
                    rep_q.code <= ST_IDLE;
                end
            end else if (run_chr) begin
                if (hit_w) begin
                    phase_q     <= PH_HUNT;
                    rep_q.code  <= ST_ABORT;
                    rep_q.abort <= 1'b1;
                end else if (last_w) begin
                    phase_q    <= PH_HUNT;
                    rep_q.code <= is_match ? ST_END : ST_MISM;
                    rep_q.pass <= is_match;
                    rep_q.err  <= !is_match;
                end else begin
                    rep_q.code <= is_match ? ST_MATCH : ST_MISM;
                    rep_q.err  <= !is_match;
                end
            end
        end
    end

    assign status = rep_q.code;
    assign pass   = rep_q.pass;
    assign err    = rep_q.err;
    assign abort  = rep_q.abort;

    AST_IDLE_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
        !bist_en |=> (status == ST_IDLE && !pass && !err && !abort));  // R1
    AST_HUNT_REF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HUNT) |-> (ref_w == '0));  // R8
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pass, err, abort}));  // R6
    AST_HOLD_NO_VLD: assert property (@(posedge clk) disable iff (rst)
        (bist_en && !chr_vld) |=> ($stable(status) && !pass && !err && !abort));  // R6
    AST_ABORT_TO_HUNT: assert property (@(posedge clk) disable iff (rst)
        abort |-> (status == ST_ABORT && phase_q == PH_HUNT));  // R8
    AST_HUNT_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (bist_en && hunt_chr) |=> !err);  // R2

endmodule

// File: tb/rx_bist_checker_test.sv
module rx_bist_checker_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bist_en = 1'b0;
    logic       chr_vld = 1'b0;
    logic [7:0] chr_data = 8'h00;
    logic       chr_ctl = 1'b0;
    logic [2:0] status;
    logic       pass, err, abort;

    always #5 clk = ~clk;

    rx_bist_checker uut (
        .clk(clk), .rst(rst), .bist_en(bist_en), .chr_vld(chr_vld),
        .chr_data(chr_data), .chr_ctl(chr_ctl),
        .status(status), .pass(pass), .err(err), .abort(abort)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string req     = "R1";

    // behavioural reference model
    bit       m_run;
    bit [7:0] m_ref;
    int       m_bal;
    bit [2:0] m_st;
    bit       m_p, m_e, m_a;

    function automatic bit [7:0] nxt(input bit [7:0] s);
        bit nb;
        nb = !(s[7] ^ s[5] ^ s[4] ^ s[3]);  // R4 feedback
        return {s[6:0], nb};
    endfunction

    task automatic model_clear();
        m_run = 0; m_ref = 0; m_bal = 0; m_st = 0; m_p = 0; m_e = 0; m_a = 0;
    endtask

    task automatic model_step();
        bit m;
        if (!bist_en) begin
            model_clear();
            return;
        end
        m_p = 0; m_e = 0; m_a = 0;
        if (!chr_vld) return;
        if (!m_run) begin
            if (!chr_ctl && chr_data == 8'h00) begin
                m_run = 1; m_ref = nxt(8'h00); m_st = 3'b001;
            end else m_st = 3'b000;
        end else begin
            m = !chr_ctl && (chr_data == m_ref);
            if (m) begin if (m_bal > 0) m_bal--; end
            else m_bal++;
            if (!m && m_bal == 16) begin
                m_st = 3'b100; m_a = 1; m_run = 0; m_ref = 0; m_bal = 0;
            end else if (nxt(m_ref) == 8'h00) begin
                m_st = m ? 3'b011 : 3'b010; m_p = m; m_e = !m;
                m_run = 0; m_ref = 0; m_bal = 0;
            end else begin
                m_st = m ? 3'b001 : 3'b010; m_e = !m; m_ref = nxt(m_ref);
            end
        end
    endtask

    task automatic compare();
        n_tests++;
        if (status !== m_st || pass !== m_p || err !== m_e || abort !== m_a) begin
            n_fail++;
            $display("FAIL %s: got st=%b p=%b e=%b a=%b, expected st=%b p=%b e=%b a=%b",
                     req, status, pass, err, abort, m_st, m_p, m_e, m_a);
        end
    endtask

    task automatic cyc(input bit en, input bit v, input bit [7:0] d, input bit c);
        @(negedge clk);
        bist_en = en; chr_vld = v; chr_data = d; chr_ctl = c;
        @(posedge clk);
        model_step();
        #1 compare();
    endtask

    // send the character the model currently expects (a good character)
    task automatic good_chr();
        cyc(1, 1, m_run ? m_ref : 8'h00, 0);
    endtask

    task automatic bad_chr();
        cyc(1, 1, m_ref ^ 8'h5A, 0);
    endtask

    task automatic check_flag(input bit ok, input string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s (actual st=%b, expected condition not met)", req, what, status);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        model_clear();
        repeat (3) @(posedge clk);
        #1 compare();
        @(negedge clk) rst = 1'b0;
        @(posedge clk); model_step(); #1 compare();

        // R2 hunting: word-sync control characters and nonzero data skipped
        req = "R2";
        for (int i = 0; i < 16; i++) cyc(1, 1, 8'hBC, 1);
        cyc(1, 1, 8'h55, 0);
        cyc(1, 1, 8'h00, 1);
        check_flag(status == 3'b000 && !err, "R2 control 0x00 must not lock");

        // R3 lock, R4 sequence
        req = "R3";
        cyc(1, 1, 8'h00, 0);
        check_flag(status == 3'b001, "R3 lock on data 0x00");
        req = "R4";
        for (int i = 0; i < 30; i++) good_chr();

        // R6 hold with gaps
        req = "R6";
        for (int i = 0; i < 4; i++) begin
            cyc(1, 0, 8'hFF, 0);
            good_chr();
        end
        bad_chr();
        cyc(1, 0, 8'h00, 0);
        check_flag(status == 3'b010 && !err, "R6 status held, err one cycle");

        // R5 mismatches incl. control character in run
        req = "R5";
        bad_chr();
        cyc(1, 1, m_ref, 1);
        good_chr(); good_chr();

        // R1 disable mid-run
        req = "R1";
        cyc(0, 1, m_ref, 0);
        cyc(0, 0, 8'h00, 0);
        cyc(1, 1, 8'h37, 0);

        // R7 credit not banked, R8 abort
        req = "R7";
        cyc(1, 1, 8'h00, 0);
        for (int i = 0; i < 40; i++) good_chr();
        for (int i = 0; i < 15; i++) bad_chr();
        check_flag(status == 3'b010, "R7 no abort before 16th mismatch");
        req = "R8";
        bad_chr();
        check_flag(abort && status == 3'b100, "R8 abort on 16th excess mismatch");
        good_chr();
        for (int i = 0; i < 10; i++) good_chr();
        // R7 mixed: mismatch/match alternation never aborts
        req = "R7";
        for (int i = 0; i < 20; i++) begin bad_chr(); good_chr(); end

        // R9 full pass
        req = "R9";
        cyc(0, 0, 8'h00, 0);
        for (int i = 0; i < 16; i++) cyc(1, 1, 8'hBC, 1);
        for (int i = 0; i < 255; i++) good_chr();
        check_flag(pass && status == 3'b011, "R9 pass at sequence end");
        cyc(1, 1, 8'h11, 0);
        check_flag(status == 3'b000, "R9 hunting after end");

        // R10 last character wrong
        req = "R10";
        for (int i = 0; i < 16; i++) cyc(1, 1, 8'hBC, 1);
        for (int i = 0; i < 254; i++) good_chr();
        bad_chr();
        check_flag(err && status == 3'b010, "R10 err at sequence end");
        good_chr();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule